// File: doc/BRIEF.md
# Bit-Latched I/O Port with External Bus Handover

This block is the logic side of an 8-bit microcontroller I/O port. A CPU-writable latch holds one bit per pin. The CPU reads data back on two separate paths. One returns the latch contents. The other returns the synchronised level seen on the pins. Each pin is driven through three enables: drive-low, strong-high and weak pull-up. The level on each pin comes back in on a sampled input.

A small ownership state machine decides who controls the pins. It has two states.
- `ST_GPIO`: the latch controls the pins.
- `ST_EXTBUS`: an internal memory bus controls the pins, push-pull.

There are two transitions. `GO_EXT` is taken on the clock edge at which `ext_en` is high. `GO_GPIO` is taken on the clock edge at which `ext_en` is low.

A parameter selects one of two port flavours:
- **Multiplexed address/data port.** It is open-drain in GPIO mode. While the bus owns the pins, its latch is forced to all ones.
- **Address-only port.** It uses a pull-up in GPIO mode. Its latch is left alone during bus ownership. It presents the high address byte, or the middle or high byte for 24-bit data accesses.

Top module: `xport_top`

## Requirements
- R1: After reset the latch reads 8'hFF, the pin synchroniser holds 8'hFF and the state is ST_GPIO, so all pins are released.
- R2: In ST_GPIO, a clock edge with `wr_latch` high loads `wr_data` into the latch.
- R3: `rd_data` equals the latch when `rd_latch` is high. It equals the synchronised pins when only `rd_pin` is high. It is 0 when neither strobe is high. `rd_latch` wins if both strobes are high.
- R4: The read-pin value is `pin_in` delayed by two clock edges through a two-flop synchroniser.
- R5: Multiplexed flavour (FLAVOUR=0) in ST_GPIO: `drv_low` = ~latch, `drv_high` = 0 and `pull_up` = 0. A latch 1 therefore floats the pin.
- R6: Address-only flavour (FLAVOUR=1) in ST_GPIO: `pull_up` = latch, `drv_low` = ~latch and `drv_high` = 0.
- R7: The state becomes ST_EXTBUS on an edge with `ext_en` high and ST_GPIO on an edge with `ext_en` low. In ST_EXTBUS, `drv_high` = bus byte, `drv_low` = ~bus byte and `pull_up` = 0.
- R8: Multiplexed flavour: every clock edge in ST_EXTBUS loads all ones into the latch. This force takes priority over a `wr_latch` in the same cycle.
- R9: Address-only flavour: bus ownership never alters the latch, and `wr_latch` still loads it in ST_EXTBUS.
- R10: Bus byte selection:
  - The multiplexed flavour presents `ext_ad`.
  - The address-only flavour presents `ext_addr_hi` when `ext_wide` = 0.
  - With `ext_wide` = 1, it presents `ext_addr_mid` when `ext_mid_sel` = 1 and `ext_addr_hi` when `ext_mid_sel` = 0.
- R11: On any pin, `drv_low` is never high together with `drv_high` or with `pull_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_latch | input | 1 | Write strobe for the port latch |
| wr_data | input | 8 | Data written to the latch |
| rd_latch | input | 1 | Read strobe, latch path |
| rd_pin | input | 1 | Read strobe, pin path |
| rd_data | output | 8 | Read-back data to the internal bus |
| ext_en | input | 1 | External memory access active |
| ext_ad | input | 8 | Low address / data byte (multiplexed flavour) |
| ext_addr_mid | input | 8 | Middle address byte (address-only flavour) |
| ext_addr_hi | input | 8 | High address byte (address-only flavour) |
| ext_wide | input | 1 | 24-bit data access in progress |
| ext_mid_sel | input | 1 | Present middle byte during a 24-bit access |
| pin_in | input | 8 | Sampled pin levels |
| drv_low | output | 8 | Per-pin pull-down enable |
| drv_high | output | 8 | Per-pin strong drive-high enable |
| pull_up | output | 8 | Per-pin weak pull-up enable |

## Verification
A CPU write to the latch and the external-bus force of all ones can land on the same clock edge. The bench provokes this by keeping `ext_en` high until the state is ST_EXTBUS, then raising `wr_latch` with a distinctive byte. The multiplexed instance must read back 8'hFF. The address-only instance, given the same stimulus, must read back the written byte. The two read strobes being active together is also exercised, with the latch path expected to win.

// File: rtl/xport_pkg.sv
package xport_pkg;

    typedef enum logic {
        FLAV_MUX_AD    = 1'b0,
        FLAV_ADDR_ONLY = 1'b1
    } flav_e;

    typedef enum logic {
        ST_GPIO   = 1'b0,
        ST_EXTBUS = 1'b1
    } own_e;

endpackage

// File: rtl/xport_sync.sv
module xport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] IDLE = {W{1'b1}};

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= IDLE;
            q      <= IDLE;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/xport_ctrl.sv
module xport_ctrl
    import xport_pkg::*;
#(
    parameter flav_e FLAVOUR = FLAV_MUX_AD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_en,
    output logic ext_mode,
    output logic force_ones
);
    own_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GPIO:   if (ext_en)  state_nx = ST_EXTBUS;   // GO_EXT
            ST_EXTBUS: if (!ext_en) state_nx = ST_GPIO;     // GO_GPIO
            default:   state_nx = ST_GPIO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_GPIO;
        else        state <= state_nx;
    end

    always_comb begin
        ext_mode   = 1'b0;
        force_ones = 1'b0;
        unique case (state)
            ST_GPIO: begin
                ext_mode   = 1'b0;
                force_ones = 1'b0;
            end
            ST_EXTBUS: begin
                ext_mode   = 1'b1;
                force_ones = (FLAVOUR == FLAV_MUX_AD);
            end
            default: begin
                ext_mode   = 1'b0;
                force_ones = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xport_latch.sv
module xport_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wd,
    input  logic         force_ones,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= ONES;
        else if (force_ones) q <= ONES;
        else if (wr)         q <= wd;
    end
endmodule

// File: rtl/xport_drive.sv
module xport_drive
    import xport_pkg::*;
#(
    parameter int    W       = 8,
    parameter flav_e FLAVOUR = FLAV_MUX_AD
) (
    input  logic         ext_mode,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] ext_ad,
    input  logic [W-1:0] ext_addr_mid,
    input  logic [W-1:0] ext_addr_hi,
    input  logic         ext_wide,
    input  logic         ext_mid_sel,
    output logic [W-1:0] drv_low,
    output logic [W-1:0] drv_high,
    output logic [W-1:0] pull_up
);
    logic [W-1:0] bus_byte;
    logic [W-1:0] gpio_pull;

    generate
        if (FLAVOUR == FLAV_MUX_AD) begin : g_mux
            assign bus_byte  = ext_ad;
            assign gpio_pull = '0;
        end else begin : g_addr
            assign bus_byte  = (ext_wide && ext_mid_sel) ? ext_addr_mid : ext_addr_hi;
            assign gpio_pull = latch_q;
        end
    endgenerate

    always_comb begin
        if (ext_mode) begin
            drv_high = bus_byte;
            drv_low  = ~bus_byte;
            pull_up  = '0;
        end else begin
            drv_high = '0;
            drv_low  = ~latch_q;
            pull_up  = gpio_pull;
        end
    end
endmodule

// File: rtl/xport_top.sv
module xport_top
    import xport_pkg::*;
#(
    parameter int    W       = 8,
    parameter flav_e FLAVOUR = FLAV_MUX_AD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_latch,
    input  logic [W-1:0] wr_data,
    input  logic         rd_latch,
    input  logic         rd_pin,
    output logic [W-1:0] rd_data,
    input  logic         ext_en,
    input  logic [W-1:0] ext_ad,
    input  logic [W-1:0] ext_addr_mid,
    input  logic [W-1:0] ext_addr_hi,
    input  logic         ext_wide,
    input  logic         ext_mid_sel,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] drv_low,
    output logic [W-1:0] drv_high,
    output logic [W-1:0] pull_up
);
    logic         ext_mode;
    logic         force_ones;
    logic [W-1:0] latch_q;
    logic [W-1:0] pin_sync;

    xport_ctrl #(.FLAVOUR(FLAVOUR)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_en     (ext_en),
        .ext_mode   (ext_mode),
        .force_ones (force_ones)
    );

    xport_latch #(.W(W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_latch),
        .wd         (wr_data),
        .force_ones (force_ones),
        .q          (latch_q)
    );

    xport_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    xport_drive #(.W(W), .FLAVOUR(FLAVOUR)) u_drive (
        .ext_mode     (ext_mode),
        .latch_q      (latch_q),
        .ext_ad       (ext_ad),
        .ext_addr_mid (ext_addr_mid),
        .ext_addr_hi  (ext_addr_hi),
        .ext_wide     (ext_wide),
        .ext_mid_sel  (ext_mid_sel),
        .drv_low      (drv_low),
        .drv_high     (drv_high),
        .pull_up      (pull_up)
    );

    always_comb begin
        if (rd_latch)    rd_data = latch_q;
        else if (rd_pin) rd_data = pin_sync;
        else             rd_data = '0;
    end
endmodule

// File: rtl/xport_top_chk.sv
module xport_top_chk
    import xport_pkg::*;
#(
    parameter int    W       = 8,
    parameter flav_e FLAVOUR = FLAV_MUX_AD
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_latch,
    input logic [W-1:0] wr_data,
    input logic         rd_latch,
    input logic         rd_pin,
    input logic [W-1:0] rd_data,
    input logic         ext_mode,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] drv_low,
    input logic [W-1:0] drv_high,
    input logic [W-1:0] pull_up
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R11
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_low & drv_high) == '0) && ((drv_low & pull_up) == '0));

    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && wr_latch) |=> (latch_q == $past(wr_data)));

    // R4
    pin_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && rd_pin && !rd_latch) |-> (rd_data == $past(pin_in, 2)));

    // R7
    ext_pushpull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> ((drv_high == ~drv_low) && (pull_up == '0)));

    // R5
    gpio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> ((drv_low == ~latch_q) && (drv_high == '0)));

    generate
        if (FLAVOUR == FLAV_MUX_AD) begin : g_mux_chk
            // R8
            force_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ext_mode |=> (latch_q == {W{1'b1}}));
        end else begin : g_addr_chk
            // R9
            latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ext_mode && !wr_latch) |=> $stable(latch_q));
            // R6
            gpio_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ext_mode |-> (pull_up == latch_q));
        end
    endgenerate
endmodule

bind xport_top xport_top_chk #(.W(W), .FLAVOUR(FLAVOUR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_latch (wr_latch),
    .wr_data  (wr_data),
    .rd_latch (rd_latch),
    .rd_pin   (rd_pin),
    .rd_data  (rd_data),
    .ext_mode (ext_mode),
    .latch_q  (latch_q),
    .pin_in   (pin_in),
    .drv_low  (drv_low),
    .drv_high (drv_high),
    .pull_up  (pull_up)
);

// File: tb/xport_top_bench.sv
module xport_top_bench;
    import xport_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_latch = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_latch = 1'b0;
    logic         rd_pin = 1'b0;
    logic         ext_en = 1'b0;
    logic [W-1:0] ext_ad = '0;
    logic [W-1:0] ext_addr_mid = '0;
    logic [W-1:0] ext_addr_hi = '0;
    logic         ext_wide = 1'b0;
    logic         ext_mid_sel = 1'b0;
    logic [W-1:0] pin_in = '1;

    logic [W-1:0] m_rd, m_lo, m_hi, m_pu;
    logic [W-1:0] a_rd, a_lo, a_hi, a_pu;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xport_top #(.W(W), .FLAVOUR(FLAV_MUX_AD)) u_xport_top (
        .clk(clk), .rst_n(rst_n), .wr_latch(wr_latch), .wr_data(wr_data),
        .rd_latch(rd_latch), .rd_pin(rd_pin), .rd_data(m_rd), .ext_en(ext_en),
        .ext_ad(ext_ad), .ext_addr_mid(ext_addr_mid), .ext_addr_hi(ext_addr_hi),
        .ext_wide(ext_wide), .ext_mid_sel(ext_mid_sel), .pin_in(pin_in),
        .drv_low(m_lo), .drv_high(m_hi), .pull_up(m_pu)
    );

    xport_top #(.W(W), .FLAVOUR(FLAV_ADDR_ONLY)) u_xport_top_ao (
        .clk(clk), .rst_n(rst_n), .wr_latch(wr_latch), .wr_data(wr_data),
        .rd_latch(rd_latch), .rd_pin(rd_pin), .rd_data(a_rd), .ext_en(ext_en),
        .ext_ad(ext_ad), .ext_addr_mid(ext_addr_mid), .ext_addr_hi(ext_addr_hi),
        .ext_wide(ext_wide), .ext_mid_sel(ext_mid_sel), .pin_in(pin_in),
        .drv_low(a_lo), .drv_high(a_hi), .pull_up(a_pu)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic to_negedge();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_latch = 1'b1;
        #1;
        chk("R1", "mux latch",  m_rd, 8'hFF);
        chk("R1", "ao latch",   a_rd, 8'hFF);
        chk("R1", "mux drv_low", m_lo, 8'h00);
        chk("R1", "ao pull_up", a_pu, 8'hFF);
        chk("R1", "mux drv_high", m_hi, 8'h00);
        rd_latch = 1'b0;
        rd_pin   = 1'b1;
        #1;
        chk("R1", "sync idle", m_rd, 8'hFF);
        rd_pin = 1'b0;
    endtask

    task automatic t_write_gpio();
        to_negedge();
        wr_latch = 1'b1; wr_data = 8'hA5;
        tick();
        wr_latch = 1'b0;
        rd_latch = 1'b1;
        #1;
        chk("R2", "mux latch", m_rd, 8'hA5);
        chk("R2", "ao latch",  a_rd, 8'hA5);
        chk("R5", "mux drv_low", m_lo, 8'h5A);
        chk("R5", "mux pull_up", m_pu, 8'h00);
        chk("R5", "mux drv_high", m_hi, 8'h00);
        chk("R6", "ao pull_up", a_pu, 8'hA5);
        chk("R6", "ao drv_low", a_lo, 8'h5A);
        chk("R6", "ao drv_high", a_hi, 8'h00);
        rd_latch = 1'b0;
    endtask

    task automatic t_read_paths();
        to_negedge();
        pin_in = 8'h3C; rd_pin = 1'b1;
        tick();
        chk("R4", "one edge old", m_rd, 8'hFF);
        tick();
        chk("R4", "two edges", m_rd, 8'h3C);
        chk("R4", "two edges ao", a_rd, 8'h3C);
        rd_latch = 1'b1;
        #1;
        chk("R3", "both strobes", m_rd, 8'hA5);
        rd_latch = 1'b0; rd_pin = 1'b0;
        #1;
        chk("R3", "no strobe", m_rd, 8'h00);
    endtask

    task automatic t_ext_enter();
        to_negedge();
        ext_en = 1'b1; ext_ad = 8'h96; ext_addr_mid = 8'h11; ext_addr_hi = 8'h22;
        ext_wide = 1'b0; ext_mid_sel = 1'b0;
        #1;
        chk("R7", "still gpio", m_lo, 8'h5A);
        tick();
        chk("R7", "mux drv_high", m_hi, 8'h96);
        chk("R7", "mux drv_low",  m_lo, 8'h69);
        chk("R7", "ao pull_up",   a_pu, 8'h00);
        chk("R10", "ao hi byte",  a_hi, 8'h22);
        rd_latch = 1'b1;
        #1;
        chk("R8", "mux latch pre-force", m_rd, 8'hA5);
        tick();
        chk("R8", "mux latch forced", m_rd, 8'hFF);
        chk("R9", "ao latch kept",    a_rd, 8'hA5);
        rd_latch = 1'b0;
    endtask

    task automatic t_write_vs_force();
        to_negedge();
        wr_latch = 1'b1; wr_data = 8'h0F;
        tick();
        wr_latch = 1'b0;
        rd_latch = 1'b1;
        #1;
        chk("R8", "force beats write", m_rd, 8'hFF);
        chk("R9", "ao write in ext",   a_rd, 8'h0F);
        rd_latch = 1'b0;
    endtask

    task automatic t_wide_select();
        to_negedge();
        ext_wide = 1'b1; ext_mid_sel = 1'b1;
        #1;
        chk("R10", "wide mid", a_hi, 8'h11);
        chk("R10", "wide mid low", a_lo, 8'hEE);
        ext_mid_sel = 1'b0;
        #1;
        chk("R10", "wide hi", a_hi, 8'h22);
        chk("R10", "mux ignores wide", m_hi, 8'h96);
        ext_wide = 1'b0; ext_mid_sel = 1'b1;
        #1;
        chk("R10", "narrow hi", a_hi, 8'h22);
    endtask

    task automatic t_ext_exit();
        to_negedge();
        ext_en = 1'b0;
        tick();
        chk("R7", "mux back gpio low", m_lo, 8'h00);
        chk("R7", "mux back gpio high", m_hi, 8'h00);
        chk("R6", "ao pull after exit", a_pu, 8'h0F);
        chk("R6", "ao low after exit", a_lo, 8'hF0);
        chk("R11", "ao no overlap", a_lo & a_pu, 8'h00);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        t_reset();
        to_negedge();
        rst_n = 1'b1;
        repeat (2) tick();
        t_write_gpio();
        t_read_paths();
        t_ext_enter();
        t_write_vs_force();
        t_wide_select();
        t_ext_exit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule